// File: doc/BRIEF.md
# Wired Four-Valued Bus Resolver

This block combines the contributions of a parameterised number of drivers onto one shared signal that carries four logic values. Every value is a two-bit code: 2'b00 is logic 0, 2'b01 is logic 1, 2'b10 is high impedance (Z) and 2'b11 is unknown (X). Each driver has its own enable bit. A driver whose enable is low is treated as switched off and takes no part in the result. The enabled contributions are folded together one driver at a time through a fixed pairwise merge rule. The fold starts from the rule's neutral value.

A build-time kind parameter sets what the output shows when every driver is off. In bus kind the output falls back to the rule's idle value. In register kind the output shows the last value resolved while some driver was on. A two-bit register holds that value and loads it on each rising clock edge. A second build-time parameter picks the merge rule. The wired rule lets a single strong value win and gives X on a conflict. The OR rule is the alternative. A flag output reports that no driver is enabled.

The resolved value is combinational from the driver and enable inputs. Only the register-kind hold value is clocked. It is cleared by a synchronous active-high reset.

Top module: `wired_bus_resolver`

## Requirements
- R1: Wired rule, pairwise merge: X merged with any value gives X; Z merged with v gives v; 0 with 0 gives 0; 1 with 1 gives 1; 0 with 1 gives X (codes 00=0, 01=1, 10=Z, 11=X).
- R2: Wired rule: the result is the merge, in driver order, of every enabled contribution, starting from Z; a single enabled driver passes its value straight through.
- R3: A driver whose enable bit is low has no effect on `res_o`, whatever code it presents.
- R4: Bus kind, wired rule: with every enable low, `res_o` is Z (2'b10).
- R5: Register kind: with every enable low, `res_o` equals the value resolved at the last rising edge where at least one driver was enabled.
- R6: While at least one driver is enabled, bus kind and register kind give the same `res_o` for the same inputs.
- R7: `none_on_o` is 1 exactly when all bits of `en_i` are 0.
- R8: A rising edge with `rst_i` high sets the register-kind hold value to Z, so all drivers off after reset shows 2'b10.
- R9: OR rule: starts from 0 and stays 0 with no driver on. An enabled 1 makes the result 1. Otherwise any enabled Z or X makes it X. Otherwise the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the register-kind hold value |
| rst_i | input | 1 | Synchronous active-high reset of the hold value |
| en_i | input | N | Per-driver enable, bit k for driver k |
| drv_i | input | 2*N | Driver codes, driver k at bits [2k+1:2k] |
| res_o | output | 2 | Resolved four-valued result |
| none_on_o | output | 1 | High when no driver is enabled |

## Verification
The assertions assume three things about the inputs. Reset is high from time zero through the first rising edge. Enables and driver codes change only away from the rising edge, so the sampled `res_o` is the settled combinational value. The hold check needs the previous edge to be outside reset, since a reset edge reloads the hold value with Z rather than the resolved value.

The stimulus changes every input just after the falling edge and checks just before the next rising edge. It keeps reset high for the first cycles. It exercises all sixteen code pairs and sweeps the values of disabled drivers. It runs idle stretches after both 0 and 1 were resolved, applies a reset while drivers are on, and ends with random enable and code patterns in which all-off cycles are frequent.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef logic [1:0] lv_t;

  localparam lv_t LV_0 = 2'b00;
  localparam lv_t LV_1 = 2'b01;
  localparam lv_t LV_Z = 2'b10;
  localparam lv_t LV_X = 2'b11;

  localparam int KIND_BUS = 0;
  localparam int KIND_REG = 1;

  localparam int RULE_WIRED = 0;
  localparam int RULE_OR    = 1;

  // Neutral start value of the fold for a given rule
  function automatic lv_t seed_of(input int rule);
    return (rule == RULE_OR) ? LV_0 : LV_Z;
  endfunction
endpackage

// File: rtl/wbr_pair_merge.sv
module wbr_pair_merge
  import wbr_pkg::*;
#(
  parameter int RULE = RULE_WIRED
) (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [1:0] y_o
);
  generate
    if (RULE == RULE_OR) begin : g_or
      always_comb begin
        if (a_i == LV_1 || b_i == LV_1)
          y_o = LV_1;
        else if (a_i[1] || b_i[1])
          y_o = LV_X;
        else
          y_o = LV_0;
      end
    end else begin : g_wired
      always_comb begin
        if (a_i == LV_X || b_i == LV_X)
          y_o = LV_X;
        else if (a_i == LV_Z)
          y_o = b_i;
        else if (b_i == LV_Z)
          y_o = a_i;
        else if (a_i == b_i)
          y_o = a_i;
        else
          y_o = LV_X;
      end
    end
  endgenerate
endmodule

// File: rtl/wbr_fold.sv
module wbr_fold
  import wbr_pkg::*;
#(
  parameter int N    = 8,
  parameter int RULE = RULE_WIRED
) (
  input  logic [N-1:0]   en_i,
  input  logic [2*N-1:0] drv_i,
  output logic [1:0]     fold_o
);
  localparam lv_t SEED = seed_of(RULE);

  logic [N:0][1:0] chain;

  assign chain[0] = SEED;

  generate
    for (genvar g = 0; g < N; g++) begin : g_stage
      logic [1:0] contrib;
      // A switched-off driver is replaced by the neutral value
      assign contrib = en_i[g] ? drv_i[2*g +: 2] : SEED;
      wbr_pair_merge #(.RULE(RULE)) merge_i (
        .a_i (chain[g]),
        .b_i (contrib),
        .y_o (chain[g+1])
      );
    end
  endgenerate

  assign fold_o = chain[N];
endmodule

// File: rtl/wbr_hold.sv
module wbr_hold
  import wbr_pkg::*;
#(
  parameter int KIND = KIND_REG
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       any_on_i,
  input  logic [1:0] fold_i,
  output logic [1:0] res_o
);
  generate
    if (KIND == KIND_REG) begin : g_reg
      logic [1:0] hold_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)
          hold_q <= LV_Z;
        else if (any_on_i)
          hold_q <= fold_i;
      end
      assign res_o = any_on_i ? fold_i : hold_q;
    end else begin : g_bus
      // Fold already yields the idle value when nothing is enabled
      assign res_o = fold_i;
    end
  endgenerate
endmodule

// File: rtl/wired_bus_resolver.sv
module wired_bus_resolver
  import wbr_pkg::*;
#(
  parameter int N    = 8,
  parameter int KIND = KIND_REG,
  parameter int RULE = RULE_WIRED
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [N-1:0]   en_i,
  input  logic [2*N-1:0] drv_i,
  output logic [1:0]     res_o,
  output logic           none_on_o
);
  logic       any_on;
  logic [1:0] fold;

  assign any_on    = |en_i;
  assign none_on_o = ~any_on;

  wbr_fold #(.N(N), .RULE(RULE)) fold_i (
    .en_i   (en_i),
    .drv_i  (drv_i),
    .fold_o (fold)
  );

  wbr_hold #(.KIND(KIND)) hold_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .any_on_i (any_on),
    .fold_i   (fold),
    .res_o    (res_o)
  );
endmodule

// File: rtl/wbr_checker.sv
module wbr_checker
  import wbr_pkg::*;
#(
  parameter int N    = 8,
  parameter int KIND = KIND_REG,
  parameter int RULE = RULE_WIRED
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic [N-1:0]   en_i,
  input logic [2*N-1:0] drv_i,
  input logic [1:0]     res_o,
  input logic           none_on_o
);
  logic on_has_x;
  logic on_has_strong;

  always_comb begin
    on_has_x      = 1'b0;
    on_has_strong = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en_i[i] && drv_i[2*i +: 2] == LV_X) on_has_x = 1'b1;
      if (en_i[i] && drv_i[2*i +: 2] != LV_Z) on_has_strong = 1'b1;
    end
  end

  AST_IDLE_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    none_on_o == (en_i == '0)); // R7

  generate
    if (RULE == RULE_WIRED) begin : g_wired_chk
      AST_X_DOMINATES: assert property (@(posedge clk_i) disable iff (rst_i)
        on_has_x |-> res_o == LV_X); // R1
      AST_DRIVEN_NOT_Z: assert property (@(posedge clk_i) disable iff (rst_i)
        on_has_strong |-> res_o != LV_Z); // R2
    end
    if (RULE == RULE_WIRED && KIND == KIND_BUS) begin : g_bus_chk
      AST_BUS_IDLE_Z: assert property (@(posedge clk_i) disable iff (rst_i)
        none_on_o |-> res_o == LV_Z); // R4
    end
    if (KIND == KIND_REG) begin : g_reg_chk
      AST_REG_KEEPS_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
        (none_on_o && !$past(rst_i)) |-> res_o == $past(res_o)); // R5
      AST_RESET_TO_Z: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rst_i) && none_on_o) |-> res_o == LV_Z); // R8
    end
  endgenerate
endmodule

bind wired_bus_resolver wbr_checker #(.N(N), .KIND(KIND), .RULE(RULE)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .drv_i     (drv_i),
  .res_o     (res_o),
  .none_on_o (none_on_o)
);

// File: tb/wired_bus_resolver_tb_top.sv
`timescale 1ns/1ps
module wired_bus_resolver_tb_top;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   en  = '0;
  logic [2*N-1:0] drv = '0;
  logic [1:0]     res_reg, res_bus, res_or;
  logic           none_reg, none_bus, none_or;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;
  int hold_m     = 2;   // model of the register-kind held value

  always #2.5 clk = ~clk;

  wired_bus_resolver #(.N(N), .KIND(1), .RULE(0)) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .drv_i(drv),
    .res_o(res_reg), .none_on_o(none_reg));

  wired_bus_resolver #(.N(N), .KIND(0), .RULE(0)) dut_bus_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .drv_i(drv),
    .res_o(res_bus), .none_on_o(none_bus));

  wired_bus_resolver #(.N(N), .KIND(0), .RULE(1)) dut_or_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .drv_i(drv),
    .res_o(res_or), .none_on_o(none_or));

  // Behavioural resolution: 0=0, 1=1, 2=Z, 3=X
  function automatic int model(input int rule, input logic [2*N-1:0] d,
                               input logic [N-1:0] e);
    int acc = (rule == 1) ? 0 : 2;
    for (int i = 0; i < N; i++) begin
      if (e[i]) begin
        int v = int'(d[2*i +: 2]);
        if (rule == 1) begin
          if (acc == 1 || v == 1) acc = 1;
          else if (acc >= 2 || v >= 2) acc = 3;
          else acc = 0;
        end else begin
          if (acc == 3 || v == 3) acc = 3;
          else if (acc == 2) acc = v;
          else if (v == 2) acc = acc;
          else if (acc != v) acc = 3;
        end
      end
    end
    return acc;
  endfunction

  task automatic check(input int got, input int exp, input string what);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] e, input logic [2*N-1:0] d,
                      input logic r, input string tag);
    int wexp, oexp, rexp;
    @(negedge clk);
    en = e; drv = d; rst = r;
    #1;
    wexp = model(0, d, e);
    oexp = model(1, d, e);
    rexp = (e != '0) ? wexp : hold_m;
    check(int'(res_reg), rexp, {tag, " register kind"});
    check(int'(res_bus), wexp, {tag, " bus kind"});
    check(int'(res_or),  oexp, {tag, " OR rule (R9)"});
    check(int'(none_reg), (e == '0) ? 1 : 0, {tag, " idle flag (R7)"});
    if (e != '0) check(int'(res_reg), int'(res_bus), {tag, " kinds agree (R6)"});
    if (r) hold_m = 2;
    else if (e != '0) hold_m = wexp;
  endtask

  function automatic logic [2*N-1:0] put(input logic [2*N-1:0] base,
                                         input int idx, input int val);
    logic [2*N-1:0] t = base;
    t[2*idx +: 2] = val[1:0];
    return t;
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    hold_m = 2;
    // R8: after reset, all off shows Z
    step('0, '0, 1'b0, "R8 idle after reset");
    step('0, {N{2'b01}}, 1'b0, "R8 idle after reset, codes moved");

    // R1: every pair of codes on drivers 0 and 5
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        step(8'b0010_0001, put(put({N{2'b10}}, 0, a), 5, b), 1'b0, "R1 pair");

    // R2: single driver passes through, multi-driver fold
    for (int k = 0; k < N; k++)
      step(N'(1) << k, put({N{2'b11}}, k, k % 2), 1'b0, "R2 single");
    step('1, {N{2'b01}}, 1'b0, "R2 all ones");
    step('1, put({N{2'b10}}, 3, 0), 1'b0, "R2 Z with one 0");

    // R3: disabled drivers swept through every code
    for (int v = 0; v < 4; v++)
      step(8'b0000_0100, put({N{v[1:0]}}, 2, 1), 1'b0, "R3 disabled ignored");

    // R5 and R4: hold after 0, then after 1, while idle codes change
    step(8'b1000_0000, put('0, 7, 0), 1'b0, "R5 load 0");
    for (int v = 0; v < 4; v++)
      step('0, {N{v[1:0]}}, 1'b0, "R5 hold 0 / R4 bus Z");
    step(8'b0000_0010, put('0, 1, 1), 1'b0, "R5 load 1");
    for (int v = 0; v < 4; v++)
      step('0, {N{v[1:0]}}, 1'b0, "R5 hold 1 / R4 bus Z");
    step(8'b0000_0011, put(put('0, 0, 0), 1, 1), 1'b0, "R5 load X");
    step('0, '0, 1'b0, "R5 hold X");

    // R8: reset while drivers are on, then idle
    step(8'b0000_0001, put('0, 0, 1), 1'b1, "R8 reset while driven");
    step('0, '0, 1'b0, "R8 idle after mid-run reset");

    // R9: OR rule directed
    step(8'b0000_0011, put(put('0, 0, 2), 1, 1), 1'b0, "R9 Z or 1");
    step(8'b0000_0011, put(put('0, 0, 2), 1, 0), 1'b0, "R9 Z or 0");
    step(8'b0000_0011, '0, 1'b0, "R9 0 or 0");

    // Random mix, many all-off cycles
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] e = N'($urandom);
      if ($urandom_range(0, 3) == 0) e = '0;
      else if ($urandom_range(0, 2) == 0) e = e & N'($urandom);
      step(e, (2*N)'($urandom), 1'b0, "R2 R5 R6 random");
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule